// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block maps a 16-bit processor address onto a 22-bit physical memory address plus a device-space select bit, which together give a 23-bit reach where peripherals share the address space with memory. Pages are 2 KB. The low 11 address bits are the page offset and pass through unchanged. The upper 5 bits pick one of 32 pages. Instruction fetches and data accesses look in different halves of the current process's 64-entry table, so each process sees 64 KB of code and 64 KB of data.

The tables sit in a private table memory. A per-process base pointer selects a 64-entry slice of that memory. The processor raises a one-cycle request strobe with the address, a code/data flag, a write flag and the base pointer. Exactly two clocks later the block answers with either a done pulse carrying the physical address or a fault pulse. A supervisor write port loads table entries at any time.

Top module: `pvt_translator`

## Requirements
- R1: While and after reset, `done`, `fault`, `dev_sel` and `paddr` are all zero until a request is answered.
- R2: On `done`, `paddr[10:0]` equals `vaddr[10:0]` of the request.
- R3: The entry used sits at table index `base_ptr*64 + is_code*32 + vaddr[15:11]`. The supervisor port `tbl_idx` addresses the table with the same numbering, so code and data pages with equal page numbers use different entries.
- R4: An entry has bit 15 = present, bit 14 = writable, bit 13 = device space and bits 10:0 = frame number. On `done`, `paddr[21:11]` is the frame and `dev_sel` is bit 13.
- R5: A request whose entry has bit 15 clear gives `fault` and no `done`.
- R6: A write request to an entry with bit 14 clear gives `fault` and no `done`. A read of that entry completes normally.
- R7: A request sampled at clock edge k that is accepted is answered by a single-cycle `done` or `fault` registered at edge k+2. Neither output is high in the cycle between.
- R8: The block is busy from the edge that accepts a request through the edge that ends its answer pulse (edges k+1 and k+2). A request sampled at those edges is ignored and produces no answer.
- R9: A supervisor write on the same edge that accepts a request to that entry does not affect that request. Later requests use the new value.
- R10: `done` and `fault` are never high together. During `fault`, `paddr` and `dev_sel` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Translation request strobe |
| vaddr | input | 16 | Virtual address |
| is_code | input | 1 | 1 = instruction fetch, 0 = data access |
| is_write | input | 1 | 1 = write access |
| base_ptr | input | 4 | Table slice of the current process |
| tbl_we | input | 1 | Supervisor table write enable |
| tbl_idx | input | 10 | Supervisor table index |
| tbl_wdata | input | 16 | Supervisor table entry value |
| paddr | output | 22 | Physical memory address |
| dev_sel | output | 1 | Physical address lies in device space |
| done | output | 1 | Translation complete pulse |
| fault | output | 1 | Translation refused pulse |

## Verification
The assertions assume that `req` is low during reset. They also assume that the caller reads `paddr` only while `done` is high. The latency and offset properties look back two cycles at `req` and `vaddr`, so they rely on the request being sampled with stable inputs at its accepting edge.

The bench drives every input half a cycle away from the sampling edge. It fills every table entry the stimulus can reach before any translation is requested, so no request reads an unwritten entry. Base pointers are kept to the slices that were loaded.

// File: rtl/pvt_pkg.sv
// Package: shared entry layout for the paged translator.
// Assumes one 16-bit table entry format used by both the table memory and the resolver.
package pvt_pkg;
    localparam int ENTRY_W     = 16;
    localparam int FRAME_W     = 11;
    localparam int PRESENT_BIT = 15;
    localparam int WRITE_BIT   = 14;
    localparam int DEVICE_BIT  = 13;

    typedef struct packed {
        logic               present;
        logic               writable;
        logic               device;
        logic [1:0]         spare;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    // Returns 1 when the access must be refused.
    function automatic logic pte_refuses(input pte_t e, input logic wr);
        return (!e.present) || (wr && !e.writable);
    endfunction
endpackage

// File: rtl/pvt_index_gen.sv
// Forms the table memory address from base pointer, access type and page number.
// Assumes each process owns a contiguous slice of 2*2^VPN_W entries.
module pvt_index_gen #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 11,
    parameter int BP_W  = 4,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int AW    = BP_W + VPN_W + 1
) (
    input  logic [BP_W-1:0] base_ptr,
    input  logic            is_code,
    input  logic [VA_W-1:0] vaddr,
    output logic [AW-1:0]   tbl_addr
);
    logic [OFF_W-1:0] unused_off;

    // Slice select, half select, then page number.
    always_comb begin
        tbl_addr   = {base_ptr, is_code, vaddr[VA_W-1:OFF_W]};
        unused_off = vaddr[OFF_W-1:0];
    end
endmodule

// File: rtl/pvt_table_mem.sv
// Table memory with one synchronous read port and one write port.
// A read and a write to one address on the same edge return the old contents.
module pvt_table_mem #(
    parameter int AW = 10,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] cells [DEPTH];

    // Registered read and supervisor write.
    always_ff @(posedge clk) begin
        rdata <= cells[raddr];
        if (we) begin
            cells[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/pvt_resolve.sv
// Turns a fetched table entry into the registered answer (done or fault).
// Assumes 'valid' is high for exactly one cycle per accepted request.
module pvt_resolve #(
    parameter int OFF_W = 11,
    localparam int PA_W = pvt_pkg::FRAME_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic                 wr,
    input  logic [OFF_W-1:0]     offset,
    input  logic [pvt_pkg::ENTRY_W-1:0] entry_raw,
    output logic [PA_W-1:0]      paddr,
    output logic                 dev_sel,
    output logic                 done,
    output logic                 fault
);
    import pvt_pkg::*;

    pte_t entry;
    logic refuse;
    logic unused_spare;

    // Decode the entry and the permission outcome.
    always_comb begin
        entry        = pte_t'(entry_raw);
        refuse       = pte_refuses(entry, wr);
        unused_spare = ^entry.spare;
    end

    // Register the one-cycle answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr   <= '0;
            dev_sel <= 1'b0;
            done    <= 1'b0;
            fault   <= 1'b0;
        end else if (valid) begin
            done    <= !refuse;
            fault   <= refuse;
            paddr   <= refuse ? '0 : {entry.frame, offset};
            dev_sel <= refuse ? 1'b0 : entry.device;
        end else begin
            paddr   <= '0;
            dev_sel <= 1'b0;
            done    <= 1'b0;
            fault   <= 1'b0;
        end
    end
endmodule

// File: rtl/pvt_translator.sv
// Top: paged virtual-to-physical translator with split code/data tables.
// Request accepted only when idle; answer two clocks later; supervisor port always live.
module pvt_translator #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 11,
    parameter int BP_W  = 4,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int TBL_AW = BP_W + VPN_W + 1,
    localparam int PA_W  = pvt_pkg::FRAME_W + OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [VA_W-1:0]             vaddr,
    input  logic                        is_code,
    input  logic                        is_write,
    input  logic [BP_W-1:0]             base_ptr,
    input  logic                        tbl_we,
    input  logic [TBL_AW-1:0]           tbl_idx,
    input  logic [pvt_pkg::ENTRY_W-1:0] tbl_wdata,
    output logic [PA_W-1:0]             paddr,
    output logic                        dev_sel,
    output logic                        done,
    output logic                        fault
);
    logic [TBL_AW-1:0]           rd_addr;
    logic [pvt_pkg::ENTRY_W-1:0] rd_entry;
    logic                        s1_valid;
    logic                        s1_write;
    logic [OFF_W-1:0]            s1_offset;
    logic                        busy;
    logic                        accept;

    // Busy while a request is in flight or its answer is on the outputs.
    always_comb begin
        busy   = s1_valid || done || fault;
        accept = req && !busy;
    end

    pvt_index_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .BP_W(BP_W)) u_index (
        .base_ptr (base_ptr),
        .is_code  (is_code),
        .vaddr    (vaddr),
        .tbl_addr (rd_addr)
    );

    pvt_table_mem #(.AW(TBL_AW), .DW(pvt_pkg::ENTRY_W)) u_table (
        .clk   (clk),
        .raddr (rd_addr),
        .rdata (rd_entry),
        .we    (tbl_we),
        .waddr (tbl_idx),
        .wdata (tbl_wdata)
    );

    // Hold the request attributes while the table read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_write  <= 1'b0;
            s1_offset <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_write  <= is_write;
                s1_offset <= vaddr[OFF_W-1:0];
            end
        end
    end

    pvt_resolve #(.OFF_W(OFF_W)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (s1_valid),
        .wr        (s1_write),
        .offset    (s1_offset),
        .entry_raw (rd_entry),
        .paddr     (paddr),
        .dev_sel   (dev_sel),
        .done      (done),
        .fault     (fault)
    );
endmodule

// File: rtl/pvt_translator_chk.sv
// Checker: temporal properties of the translator, attached by bind.
// Assumes req is low while rst_n is low.
module pvt_translator_chk #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 11,
    parameter int PA_W  = 22
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            accept,
    input logic            busy,
    input logic [VA_W-1:0] vaddr,
    input logic [PA_W-1:0] paddr,
    input logic            dev_sel,
    input logic            done,
    input logic            fault
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R10
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) fault |-> (paddr == '0 && !dev_sel)); // R10
    AST_ANSWER_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) accept |-> ##2 (done || fault)); // R7
    AST_ANSWER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |-> $past(req, 2)); // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> !(done || fault)); // R7
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (req && busy) |-> ##2 !(done || fault)); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (paddr[OFF_W-1:0] == $past(vaddr[OFF_W-1:0], 2))); // R2
endmodule

bind pvt_translator pvt_translator_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .accept  (accept),
    .busy    (busy),
    .vaddr   (vaddr),
    .paddr   (paddr),
    .dev_sel (dev_sel),
    .done    (done),
    .fault   (fault)
);

// File: tb/pvt_translator_test.sv
module pvt_translator_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [15:0] vaddr;
    logic        is_code;
    logic        is_write;
    logic [3:0]  base_ptr;
    logic        tbl_we;
    logic [9:0]  tbl_idx;
    logic [15:0] tbl_wdata;
    logic [21:0] paddr;
    logic        dev_sel;
    logic        done;
    logic        fault;

    int total = 0;
    int passed = 0;
    logic [15:0] shadow [256];

    always #2 clk = ~clk;

    pvt_translator uut (
        .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr), .is_code(is_code),
        .is_write(is_write), .base_ptr(base_ptr), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .paddr(paddr), .dev_sel(dev_sel), .done(done), .fault(fault)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act === exp) passed++;
        else $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    function automatic logic [7:0] slot(input logic [1:0] bp, input logic code, input logic [4:0] pg);
        return {bp, code, pg};
    endfunction

    // Expected answer: [23]=fault, [22]=dev, [21:0]=paddr.
    function automatic logic [23:0] model(input logic [15:0] e, input logic wr, input logic [15:0] va);
        logic refuse;
        refuse = !e[15] || (wr && !e[14]);
        if (refuse) return {1'b1, 1'b0, 22'd0};
        return {1'b0, e[13], e[10:0], va[10:0]};
    endfunction

    // Called at a negedge; returns at a negedge.
    task automatic load(input logic [1:0] bp, input logic code, input logic [4:0] pg, input logic [15:0] val);
        tbl_we = 1'b1; tbl_idx = {2'b00, slot(bp, code, pg)}; tbl_wdata = val;
        shadow[slot(bp, code, pg)] = val;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic xlate(input string tag, input logic [1:0] bp, input logic code, input logic wr, input logic [15:0] va);
        logic [23:0] e;
        e = model(shadow[slot(bp, code, va[15:11])], wr, va);
        req = 1'b1; base_ptr = {2'b00, bp}; is_code = code; is_write = wr; vaddr = va;
        @(negedge clk);
        req = 1'b0;
        chk("R7", "no early answer", {30'd0, done, fault}, 32'd0);
        @(negedge clk);
        chk(tag, "done", {31'd0, done}, {31'd0, !e[23]});
        chk(tag, "fault", {31'd0, fault}, {31'd0, e[23]});
        chk(tag, "paddr", {10'd0, paddr}, {10'd0, e[21:0]});
        chk(tag, "dev_sel", {31'd0, dev_sel}, {31'd0, e[22]});
        @(negedge clk);
        chk("R7", "pulse ends", {30'd0, done, fault}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; req = 1'b0; vaddr = '0; is_code = 1'b0; is_write = 1'b0;
        base_ptr = '0; tbl_we = 1'b0; tbl_idx = '0; tbl_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", {8'd0, done, fault, dev_sel, paddr[21:0], 1'b0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {8'd0, done, fault, dev_sel, paddr[21:0], 1'b0}, 32'd0);

        // Fill slices 0..3 with random entries.
        for (int i = 0; i < 256; i++) load(i[7:6], i[5], i[4:0], 16'($urandom));

        // R3/R4: code and data page 3 of slice 1 differ.
        load(2'd1, 1'b0, 5'd3, 16'hE7FF);
        load(2'd1, 1'b1, 5'd3, 16'h8123);
        xlate("R4", 2'd1, 1'b0, 1'b1, {5'd3, 11'h5A5});
        xlate("R3", 2'd1, 1'b1, 1'b0, {5'd3, 11'h0F0});
        // R3: same page in another slice.
        load(2'd2, 1'b0, 5'd3, 16'h8400);
        xlate("R3", 2'd2, 1'b0, 1'b0, {5'd3, 11'h7FF});
        // R5: entry absent.
        load(2'd0, 1'b0, 5'd31, 16'h7FFF);
        xlate("R5", 2'd0, 1'b0, 1'b0, {5'd31, 11'h001});
        // R6: read-only page, read then write.
        load(2'd3, 1'b1, 5'd0, 16'hA00F);
        xlate("R6", 2'd3, 1'b1, 1'b0, 16'h0123);
        xlate("R6", 2'd3, 1'b1, 1'b1, 16'h0123);
        // R2: offset extremes.
        xlate("R2", 2'd1, 1'b0, 1'b0, {5'd3, 11'h000});
        xlate("R2", 2'd1, 1'b0, 1'b0, {5'd3, 11'h7FF});

        // R8: hold req high through the busy edges with a different address.
        req = 1'b1; base_ptr = 4'd1; is_code = 1'b0; is_write = 1'b0; vaddr = {5'd3, 11'h111};
        @(negedge clk);
        vaddr = {5'd3, 11'h222};
        @(negedge clk);
        chk("R8", "first answer", {9'd0, done, paddr}, {9'd0, 1'b1, 11'h7FF, 11'h111});
        vaddr = {5'd3, 11'h333};
        @(negedge clk);
        req = 1'b0;
        chk("R8", "busy req ignored a", {30'd0, done, fault}, 32'd0);
        @(negedge clk);
        chk("R8", "busy req ignored b", {30'd0, done, fault}, 32'd0);
        @(negedge clk);

        // R9: write and request on the same edge; old entry used, new later.
        begin
            logic [15:0] old_e;
            old_e = 16'hC2AA;
            load(2'd2, 1'b1, 5'd9, old_e);
            tbl_we = 1'b1; tbl_idx = {2'b00, slot(2'd2, 1'b1, 5'd9)}; tbl_wdata = 16'h0000;
            xlate("R9", 2'd2, 1'b1, 1'b0, {5'd9, 11'h044});
            tbl_we = 1'b0;
            shadow[slot(2'd2, 1'b1, 5'd9)] = 16'h0000;
            xlate("R9", 2'd2, 1'b1, 1'b0, {5'd9, 11'h044});
        end

        // Random traffic; R10 outcomes checked on every answer.
        for (int n = 0; n < 400; n++)
            xlate("R10", 2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));

        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end
endmodule